// File: doc/BRIEF.md
# MSI Vector Capture Decoder

This block sits on the upstream side of a PCIe root port and turns inbound message-signalled interrupt writes into pending interrupt state. Each inbound write comes as an address, a data word and a one-cycle valid strobe. The block compares the address with a 64-bit doorbell address that software programs. If the address matches and the data word is a legal vector number, the block sets the pending bit for that vector. The data value is the vector index.

There are 64 vectors, split into two banks of 32. Each bank has its own pending register, its own enable register and its own level-sensitive interrupt line. A line stays high while any pending bit in its bank also has its enable bit set. Software reads the pending bits and clears them by writing ones. A write that misses the doorbell, or that carries an out-of-range vector, changes no pending bit and sets a sticky error output.

A simple register bus reaches the registers: a write strobe, a byte address, write data, and read data that is combinational from the address. The register layout by byte address is:

- `0x00`: low pending bits
- `0x04`: high pending bits
- `0x08`: low enables
- `0x0C`: high enables
- `0x10`: doorbell address bits [31:0]
- `0x14`: doorbell address bits [63:32]

Top module: `msi_vec_decoder`

## Requirements
- R1: The doorbell address is 64 bits wide. Its bits [31:0] are written and read at byte address 0x10, and its bits [63:32] at 0x14. A register write takes effect at the clock edge on which the strobe is sampled.
- R2: An inbound write takes effect when the valid strobe is high, the address equals the doorbell and the data is below 64. Vector v sets bit v of the low pending register (0x00) if v < 32, and bit v-32 of the high pending register (0x04) otherwise. The bit is visible from the cycle after the strobe.
- R3: Writing to a pending register clears exactly the bits that are 1 in the write data. Bits written as 0 keep their value.
- R4: If a vector is set by an inbound write and cleared by a register write in the same cycle, the vector stays pending. A clear of other bits in that same cycle still takes effect.
- R5: The low enable register (0x08) and the high enable register (0x0C) hold one bit per vector at the same bit position as the pending bit. A 1 enables the vector and a 0 blocks it. Both registers read back as written.
- R6: `irq[0]` is high exactly when some low pending bit is also enabled. `irq[1]` does the same for the high bank. A pending bit that is blocked by its enable bit stays pending.
- R7: An inbound write whose address differs from the doorbell, or whose data is 64 or above, leaves every pending bit unchanged. It sets `err_flag` from the next cycle onward, and `err_flag` stays high until reset.
- R8: Reset clears all pending bits, all enable bits, the doorbell address and `err_flag`. An unmapped register address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound interrupt write strobe |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data (vector number) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 2 | Bank interrupt lines: bit 0 for vectors 0-31, bit 1 for vectors 32-63 |
| err_flag | output | 1 | Sticky flag for a rejected inbound write |

## Verification
A wrong pending bit shows up in the cycle after the inbound strobe, both as a wrong read value and as a wrong bank line. Because of that, every vector is sent on its own and then read back, with its bank line checked. A clear that removes too much or too little leaves a wrong read value one cycle after the register write. A lost set in a set-against-clear collision shows up the same way. Errors in the enable or doorbell path appear as a line that does not follow pending-and-enable, or as an error flag that does not follow the address and range rules.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
  localparam int unsigned WORD_W = 32;

  // Byte offset of the pending register of bank b.
  function automatic int unsigned pend_off(int unsigned b);
    return 4 * b;
  endfunction

  // Byte offset of the enable register of bank b.
  function automatic int unsigned mask_off(int unsigned nbank, int unsigned b);
    return 4 * (nbank + b);
  endfunction

  // Byte offset of doorbell word w (0 holds bits [31:0]).
  function automatic int unsigned door_off(int unsigned nbank, int unsigned w);
    return 4 * (2 * nbank + w);
  endfunction

  // Bank that holds vector v.
  function automatic int unsigned vec_bank(int unsigned v);
    return v / WORD_W;
  endfunction

  // Bit position of vector v inside its bank.
  function automatic int unsigned vec_bit(int unsigned v);
    return v % WORD_W;
  endfunction
endpackage

// File: rtl/msi_hit_decode.sv
module msi_hit_decode #(
  parameter int unsigned NVEC   = 64,
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] door,
  output logic              hit,
  output logic              bad,
  output logic [NVEC-1:0]   set_vec
);
  logic addr_match;
  logic in_range;

  assign addr_match = (addr == door);
  assign in_range   = (data < DATA_W'(NVEC));
  assign hit        = valid && addr_match && in_range;
  assign bad        = valid && !(addr_match && in_range);

  for (genvar i = 0; i < NVEC; i++) begin : g_onehot
    assign set_vec[i] = hit && (data == DATA_W'(i));
  end
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] en_bits,
  output logic [W-1:0] pend,
  output logic         irq
);
  logic [W-1:0] pend_d;

  // A set in the same cycle as a clear wins.
  assign pend_d = (pend & ~clr_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end

  assign irq = |(pend & en_bits);
endmodule

// File: rtl/msi_reg_file.sv
module msi_reg_file
  import msi_dec_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  parameter int unsigned REG_AW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [WORD_W-1:0]       reg_wdata,
  input  logic [NBANK*WORD_W-1:0] pend,
  output logic [2*WORD_W-1:0]     door,
  output logic [NBANK*WORD_W-1:0] en_bits,
  output logic [NBANK*WORD_W-1:0] clr_vec,
  output logic [WORD_W-1:0]       reg_rdata
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [REG_AW-1:0] PEND_A = REG_AW'(pend_off(b));
    localparam logic [REG_AW-1:0] MASK_A = REG_AW'(mask_off(NBANK, b));

    assign clr_vec[b*WORD_W +: WORD_W] =
      (reg_wr && reg_addr == PEND_A) ? reg_wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)
        en_bits[b*WORD_W +: WORD_W] <= '0;
      else if (reg_wr && reg_addr == MASK_A)
        en_bits[b*WORD_W +: WORD_W] <= reg_wdata;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_door
    localparam logic [REG_AW-1:0] DOOR_A = REG_AW'(door_off(NBANK, w));
    always_ff @(posedge clk) begin
      if (!rst_n)
        door[w*WORD_W +: WORD_W] <= '0;
      else if (reg_wr && reg_addr == DOOR_A)
        door[w*WORD_W +: WORD_W] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int unsigned b = 0; b < NBANK; b++) begin
      if (reg_addr == REG_AW'(pend_off(b)))
        reg_rdata = pend[b*WORD_W +: WORD_W];
      if (reg_addr == REG_AW'(mask_off(NBANK, b)))
        reg_rdata = en_bits[b*WORD_W +: WORD_W];
    end
    for (int unsigned w = 0; w < 2; w++) begin
      if (reg_addr == REG_AW'(door_off(NBANK, w)))
        reg_rdata = door[w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/msi_vec_decoder.sv
module msi_vec_decoder
  import msi_dec_pkg::*;
#(
  parameter int unsigned NVEC   = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msi_valid,
  input  logic [2*WORD_W-1:0]   msi_addr,
  input  logic [DATA_W-1:0]     msi_data,
  input  logic                  reg_wr,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic [NVEC/WORD_W-1:0] irq,
  output logic                  err_flag
);
  localparam int unsigned NBANK  = NVEC / WORD_W;
  localparam int unsigned ADDR_W = 2 * WORD_W;

  // Named internal events, observed by the bound checker.
  logic              msi_hit;
  logic              msi_bad;
  logic [NVEC-1:0]   set_vec;
  logic [NVEC-1:0]   clr_vec;
  logic [NVEC-1:0]   pend_q;
  logic [NVEC-1:0]   mask_q;
  logic [ADDR_W-1:0] door_q;

  msi_hit_decode #(.NVEC(NVEC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .valid(msi_valid), .addr(msi_addr), .data(msi_data), .door(door_q),
    .hit(msi_hit), .bad(msi_bad), .set_vec(set_vec)
  );

  msi_reg_file #(.NBANK(NBANK), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pend(pend_q), .door(door_q), .en_bits(mask_q),
    .clr_vec(clr_vec), .reg_rdata(reg_rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    msi_pend_bank #(.W(WORD_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_bits(set_vec[b*WORD_W +: WORD_W]),
      .clr_bits(clr_vec[b*WORD_W +: WORD_W]),
      .en_bits(mask_q[b*WORD_W +: WORD_W]),
      .pend(pend_q[b*WORD_W +: WORD_W]),
      .irq(irq[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= err_flag | msi_bad;
  end
endmodule

// File: rtl/msi_vec_checker.sv
module msi_vec_checker #(
  parameter int unsigned NVEC  = 64,
  parameter int unsigned NBANK = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msi_bad,
  input logic [NVEC-1:0]  set_vec,
  input logic [NVEC-1:0]  clr_vec,
  input logic [NVEC-1:0]  pend_q,
  input logic [NVEC-1:0]  mask_q,
  input logic [NBANK-1:0] irq,
  input logic             err_flag
);
  // R2: a vector that is accepted is pending in the next cycle.
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R3: a clear with no set for the same bit removes the bit.
  a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  // R4: a set in the same cycle as a clear keeps the bit.
  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> ((pend_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)));

  // R6: no interrupt line is high while every enable bit is zero.
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (irq == '0));

  // R7: a rejected write with no clear in the same cycle leaves the pending bits alone.
  a_r7_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_bad && clr_vec == '0) |=> (pend_q == $past(pend_q)));

  // R7: the error flag holds until reset.
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind msi_vec_decoder msi_vec_checker #(.NVEC(NVEC), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_bad(msi_bad), .set_vec(set_vec),
  .clr_vec(clr_vec), .pend_q(pend_q), .mask_q(mask_q), .irq(irq),
  .err_flag(err_flag)
);

// File: tb/tb_msi_vec_decoder.sv
module tb_msi_vec_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq;
  logic        err_flag;

  int total = 0;
  int bad = 0;

  localparam logic [63:0] DOOR = 64'h0000_00A5_3C00_1000;
  localparam logic [4:0] A_PLO = 5'h00, A_PHI = 5'h04, A_MLO = 5'h08,
                         A_MHI = 5'h0C, A_DLO = 5'h10, A_DHI = 5'h14;

  always #2.5 clk = ~clk;

  msi_vec_decoder dut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  function automatic logic [31:0] bank_bits(input int v, input int b);
    if (v / 32 == b) return 32'd1 << (v % 32);
    return 32'd0;
  endfunction

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R8: reset state
    chk("R8 err", {63'd0, err_flag}, 64'd0);
    chk("R8 irq", {62'd0, irq}, 64'd0);
    foreach (r[i]) begin end
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), r);
      chk("R8 reg zero", {32'd0, r}, 64'd0);
    end

    // R1: doorbell readback
    wr(A_DLO, DOOR[31:0]);
    wr(A_DHI, DOOR[63:32]);
    rd(A_DLO, r); chk("R1 door lo", {32'd0, r}, {32'd0, DOOR[31:0]});
    rd(A_DHI, r); chk("R1 door hi", {32'd0, r}, {32'd0, DOOR[63:32]});

    // R7: out-of-range vector
    msi(DOOR, 32'd64);
    rd(A_PLO, r); chk("R7 range lo", {32'd0, r}, 64'd0);
    rd(A_PHI, r); chk("R7 range hi", {32'd0, r}, 64'd0);
    chk("R7 range err", {63'd0, err_flag}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R7 err sticky", {63'd0, err_flag}, 64'd1);

    // R7: address mismatch
    do_reset();
    chk("R8 err cleared", {63'd0, err_flag}, 64'd0);
    rd(A_DHI, r); chk("R8 door cleared", {32'd0, r}, 64'd0);
    wr(A_DLO, DOOR[31:0]);
    wr(A_DHI, DOOR[63:32]);
    msi(DOOR ^ 64'h0000_0001_0000_0000, 32'd3);
    rd(A_PLO, r); chk("R7 addr lo", {32'd0, r}, 64'd0);
    chk("R7 addr err", {63'd0, err_flag}, 64'd1);

    // R2 R3 R5 R6: sweep every vector
    do_reset();
    wr(A_DLO, DOOR[31:0]);
    wr(A_DHI, DOOR[63:32]);
    wr(A_MLO, 32'hFFFF_FFFF);
    wr(A_MHI, 32'hFFFF_FFFF);
    rd(A_MLO, r); chk("R5 mask lo readback", {32'd0, r}, 64'hFFFF_FFFF);
    for (int v = 0; v < 64; v++) begin
      msi(DOOR, 32'(v));
      rd(A_PLO, r); chk("R2 pend lo", {32'd0, r}, {32'd0, bank_bits(v, 0)});
      rd(A_PHI, r); chk("R2 pend hi", {32'd0, r}, {32'd0, bank_bits(v, 1)});
      chk("R6 irq", {62'd0, irq}, {62'd0, (v >= 32), (v < 32)});
      wr((v < 32) ? A_PLO : A_PHI, 32'd1 << (v % 32));
      rd((v < 32) ? A_PLO : A_PHI, r); chk("R3 cleared", {32'd0, r}, 64'd0);
      chk("R6 irq low", {62'd0, irq}, 64'd0);
    end
    chk("R7 err untouched by hits", {63'd0, err_flag}, 64'd0);

    // R3: selective clear, zero bits keep value
    msi(DOOR, 32'd1); msi(DOOR, 32'd2); msi(DOOR, 32'd40);
    wr(A_PLO, 32'h0000_0002);
    rd(A_PLO, r); chk("R3 selective lo", {32'd0, r}, 64'h4);
    rd(A_PHI, r); chk("R3 other bank kept", {32'd0, r}, 64'h100);
    wr(A_PLO, 32'hFFFF_FFFF); wr(A_PHI, 32'hFFFF_FFFF);

    // R4: set and clear in the same cycle
    msi(DOOR, 32'd9);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = DOOR; msi_data = 32'd7;
    reg_wr = 1'b1; reg_addr = A_PLO; reg_wdata = 32'h0000_0280;
    @(negedge clk);
    msi_valid = 1'b0; reg_wr = 1'b0;
    rd(A_PLO, r); chk("R4 set wins", {32'd0, r}, 64'h80);
    wr(A_PLO, 32'hFFFF_FFFF);

    // R5 R6: blocked vectors stay pending without a line
    wr(A_MLO, ~(32'd1 << 5));
    wr(A_MHI, ~(32'd1 << 8));
    msi(DOOR, 32'd5); msi(DOOR, 32'd40);
    rd(A_PLO, r); chk("R6 blocked pending lo", {32'd0, r}, 64'h20);
    rd(A_PHI, r); chk("R6 blocked pending hi", {32'd0, r}, 64'h100);
    chk("R5 blocked irq", {62'd0, irq}, 64'd0);
    wr(A_MLO, 32'hFFFF_FFFF);
    chk("R5 enable lo", {62'd0, irq}, 64'd1);
    wr(A_MHI, 32'hFFFF_FFFF);
    chk("R5 enable hi", {62'd0, irq}, 64'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule